// File: doc/BRIEF.md
# Target Reset Sequencer and Halt Detector

This block drives a small target processor through a controlled start-up and then tells the host when that processor has stopped. It divides a fast local clock down to the target clock. It drives the target's active-low reset. When the host asks for a restart, or after the block's own reset, the target reset goes low. It stays low for a configurable number of whole target clock cycles, which is long enough to outlast the target's internal power-up timer. The reset is then released on a rising edge of the target clock. This makes the first executed cycle repeatable to within one target clock.

After release, the block watches the clock that the target's oscillator returns. A running target returns the inverse of the clock it is given. A target that has executed its halt instruction leaves that pin stuck high or stuck low. The returned pin passes through a synchroniser. Once per target cycle the block judges that cycle good or bad. When a run of consecutive bad cycles reaches a set length, the block raises a sticky halt flag. It also latches how many good target cycles ran before the halt. A new restart request clears both results. The flag and the count are plain status pins with no handshake. The host reads them at any time, and they stay valid until the next request. There is no data stream at this block's edge, so no back-pressure applies.

Top module: `rsthalt_seq`

## Requirements
- R1: `tgt_clk` is `clk` divided by 2*DIV with equal high and low phases of DIV fast cycles. After block reset it starts with a high phase.
- R2: After block reset, `tgt_rst_n` is 0, `halt_flag` is 0 and `halt_cycles` is 0.
- R3: A hold begins at block reset or at any fast cycle in which `rst_req` is sampled 1. A request during a hold restarts it. `tgt_rst_n` stays 0 until the (HOLD_CYC+1)-th rising edge of `tgt_clk` counted after the hold begins. A rising edge in the same fast cycle as the request is not counted. This gives at least HOLD_CYC whole target cycles in reset.
- R4: `tgt_rst_n` rises on the same fast clock edge as a rising edge of `tgt_clk`.
- R5: `tgt_clk_ret` passes through SYNC_STAGES flops. A target cycle is bad if the synchronised pin is 1 in the last fast cycle of the high phase, or 0 in the last fast cycle of the low phase. Otherwise the cycle is good. The verdict is taken in the last fast cycle before the next rising edge.
- R6: `halt_flag` rises when HALT_RUN consecutive bad cycles have occurred since release. It rises on the edge that ends the last of those cycles. A good cycle resets the run of bad cycles, so a shorter bad burst never raises the flag.
- R7: `halt_cycles` takes the number of good cycles since release in the same edge that raises `halt_flag`. The count saturates at 2^CNT_W-1 (255 by default).
- R8: `halt_flag` and `halt_cycles` hold their values until the next request. The fast cycle after a sampled `rst_req` shows `tgt_rst_n`=0, `halt_flag`=0 and `halt_cycles`=0.
- R9: While `tgt_rst_n` is 0, `tgt_clk_ret` has no effect. `halt_flag` stays 0, and the count after release reflects only cycles after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast local clock (2*DIV times the target clock) |
| rst_n | input | 1 | Asynchronous active-low block reset |
| rst_req | input | 1 | Restart request from the host, sampled every fast cycle |
| tgt_clk_ret | input | 1 | Oscillator return pin of the target, asynchronous |
| tgt_clk | output | 1 | Divided clock driven to the target |
| tgt_rst_n | output | 1 | Active-low reset driven to the target |
| halt_flag | output | 1 | Sticky flag: the target has stopped |
| halt_cycles | output | CNT_W | Good target cycles counted before the halt, saturating |

## Verification
On every cycle the assertions check the following. The phase length of the divided clock is correct. Release always coincides with a target clock rising edge and comes after at least HOLD_CYC counted rising edges. A request clears the results on the next cycle. The flag and count stay frozen between requests. The flag never rises while the target is in reset, or before HALT_RUN target cycles have run. The actual value of the latched count can only be shown by the bench's scenarios. The same holds for the effect of stuck-high versus stuck-low halts, short bad bursts that must not halt, saturation at 255, and junk on the return pin during reset. Each scenario is driven by a target stub that stops after a known number of cycles.

// File: rtl/rsthalt_pkg.sv
package rsthalt_pkg;

  // Two-state sequencer: target held in reset, or released and running.
  typedef enum logic {
    SEQ_HOLD = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

endpackage

// File: rtl/rsthalt_clkdiv.sv
module rsthalt_clkdiv #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tclk,
  output logic end_hi,
  output logic end_lo
);

  localparam int PERIOD = 2 * DIV;
  localparam int PH_W   = (PERIOD > 2) ? $clog2(PERIOD) : 1;

  logic [PH_W-1:0] ph;
  logic [PH_W-1:0] ph_nx;

  // Strobes mark the last fast cycle of each half period.
  assign end_hi = (ph == PH_W'(DIV - 1));
  assign end_lo = (ph == PH_W'(PERIOD - 1));
  assign ph_nx  = end_lo ? '0 : ph + PH_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= '0;
      tclk <= 1'b1;
    end else begin
      ph   <= ph_nx;
      tclk <= (ph_nx < PH_W'(DIV));
    end
  end

endmodule

// File: rtl/rsthalt_sync.sv
module rsthalt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/rsthalt_rstseq.sv
module rsthalt_rstseq
  import rsthalt_pkg::*;
#(
  parameter int HOLD_CYC = 8192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic end_lo,
  output logic running
);

  localparam int HW = $clog2(HOLD_CYC + 1);

  seq_state_e    state;
  logic [HW-1:0] hold_cnt;

  // end_lo precedes a target rising edge, so release lands on that edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SEQ_HOLD;
      hold_cnt <= '0;
    end else if (req) begin
      state    <= SEQ_HOLD;
      hold_cnt <= '0;
    end else if (state == SEQ_HOLD && end_lo) begin
      if (hold_cnt == HW'(HOLD_CYC)) state <= SEQ_RUN;
      else                          hold_cnt <= hold_cnt + HW'(1);
    end
  end

  assign running = (state == SEQ_RUN);

endmodule

// File: rtl/rsthalt_detect.sv
module rsthalt_detect #(
  parameter int HALT_RUN = 4,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             running,
  input  logic             end_hi,
  input  logic             end_lo,
  input  logic             ret_s,
  output logic             halt,
  output logic [CNT_W-1:0] halt_cnt
);

  localparam int SW = $clog2(HALT_RUN) + 1;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic             bad_hi;
  logic [SW-1:0]    streak;
  logic [CNT_W-1:0] good;
  logic             cyc_bad;

  // High phase expects the return low; low phase expects it high.
  assign cyc_bad = bad_hi | ~ret_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bad_hi   <= 1'b0;
      streak   <= '0;
      good     <= '0;
      halt     <= 1'b0;
      halt_cnt <= '0;
    end else if (clear) begin
      bad_hi   <= 1'b0;
      streak   <= '0;
      good     <= '0;
      halt     <= 1'b0;
      halt_cnt <= '0;
    end else if (running && !halt) begin
      if (end_hi) bad_hi <= ret_s;
      if (end_lo) begin
        bad_hi <= 1'b0;
        if (cyc_bad) begin
          if (streak == SW'(HALT_RUN - 1)) begin
            halt     <= 1'b1;
            halt_cnt <= good;
          end else begin
            streak <= streak + SW'(1);
          end
        end else begin
          streak <= '0;
          if (good != CMAX) good <= good + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/rsthalt_seq.sv
module rsthalt_seq #(
  parameter int DIV         = 8,
  parameter int HOLD_CYC    = 8192,
  parameter int HALT_RUN    = 4,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_req,
  input  logic             tgt_clk_ret,
  output logic             tgt_clk,
  output logic             tgt_rst_n,
  output logic             halt_flag,
  output logic [CNT_W-1:0] halt_cycles
);

  logic end_hi, end_lo, running, ret_s;

  rsthalt_clkdiv #(.DIV(DIV)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .tclk   (tgt_clk),
    .end_hi (end_hi),
    .end_lo (end_lo)
  );

  rsthalt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (tgt_clk_ret),
    .q     (ret_s)
  );

  rsthalt_rstseq #(.HOLD_CYC(HOLD_CYC)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (rst_req),
    .end_lo  (end_lo),
    .running (running)
  );

  rsthalt_detect #(.HALT_RUN(HALT_RUN), .CNT_W(CNT_W)) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (rst_req),
    .running  (running),
    .end_hi   (end_hi),
    .end_lo   (end_lo),
    .ret_s    (ret_s),
    .halt     (halt_flag),
    .halt_cnt (halt_cycles)
  );

  assign tgt_rst_n = running;

endmodule

// File: rtl/rsthalt_checker.sv
module rsthalt_checker #(
  parameter int DIV      = 8,
  parameter int HOLD_CYC = 8192,
  parameter int HALT_RUN = 4,
  parameter int CNT_W    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_req,
  input logic             tgt_clk,
  input logic             tgt_rst_n,
  input logic             halt_flag,
  input logic [CNT_W-1:0] halt_cycles
);

  localparam int LW = $clog2(DIV + 2) + 1;
  localparam int HW = $clog2(HOLD_CYC + 1) + 1;
  localparam int RW = $clog2(HALT_RUN + 1) + 1;

  logic          clk_d;
  logic [LW-1:0] len_d;
  logic [HW-1:0] hold_rises;
  logic [RW-1:0] run_rises;
  logic          rise_seen;

  assign rise_seen = tgt_clk && !clk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_d      <= 1'b1;
      len_d      <= '0;
      hold_rises <= '0;
      run_rises  <= '0;
    end else begin
      clk_d <= tgt_clk;
      if (tgt_clk != clk_d)         len_d <= LW'(1);
      else if (len_d != LW'(DIV+1)) len_d <= len_d + LW'(1);

      if (rst_req)
        hold_rises <= '0;
      else if (rise_seen && !tgt_rst_n && hold_rises != HW'(HOLD_CYC))
        hold_rises <= hold_rises + HW'(1);

      if (!tgt_rst_n)
        run_rises <= '0;
      else if (rise_seen && run_rises != RW'(HALT_RUN))
        run_rises <= run_rises + RW'(1);
    end
  end

  assert_half_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_clk != clk_d) |-> (len_d == LW'(DIV)));

  assert_hold_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_rst_n) |-> (hold_rises == HW'(HOLD_CYC)));

  assert_release_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_rst_n) |-> $rose(tgt_clk));

  assert_min_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_flag) |-> (run_rises == RW'(HALT_RUN)));

  assert_request_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (!tgt_rst_n && !halt_flag && halt_cycles == '0));

  assert_sticky_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_flag && !rst_req) |=> (halt_flag && $stable(halt_cycles)));

  assert_quiet_in_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_rst_n |-> !halt_flag);

endmodule

bind rsthalt_seq rsthalt_checker #(
  .DIV(DIV), .HOLD_CYC(HOLD_CYC), .HALT_RUN(HALT_RUN), .CNT_W(CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rst_req     (rst_req),
  .tgt_clk     (tgt_clk),
  .tgt_rst_n   (tgt_rst_n),
  .halt_flag   (halt_flag),
  .halt_cycles (halt_cycles)
);

// File: tb/rsthalt_seq_bench.sv
`timescale 1ns/1ps
module rsthalt_seq_bench;

  localparam int DIV      = 4;
  localparam int HOLD_CYC = 6;
  localparam int HALT_RUN = 4;
  localparam int CNT_W    = 8;
  localparam int CMAX     = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_req = 1'b0;
  logic tgt_clk_ret;
  logic tgt_clk, tgt_rst_n, halt_flag;
  logic [CNT_W-1:0] halt_cycles;

  always #2.5 clk = ~clk;

  rsthalt_seq #(.DIV(DIV), .HOLD_CYC(HOLD_CYC), .HALT_RUN(HALT_RUN),
                .CNT_W(CNT_W), .SYNC_STAGES(2)) u_rsthalt_seq (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .tgt_clk_ret(tgt_clk_ret),
    .tgt_clk(tgt_clk), .tgt_rst_n(tgt_rst_n), .halt_flag(halt_flag),
    .halt_cycles(halt_cycles)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // ---------------- target stub ----------------
  int lim_n = 1000, blip_at = 0, blip_len = 0;
  bit stuck_v = 1'b1, junk_rst = 1'b0;
  logic tclk_d;
  int runs, hr;
  logic bad_now;

  always_ff @(posedge clk) begin
    tclk_d <= tgt_clk;
    if (!tgt_rst_n) runs <= 0;
    else if (tgt_clk && !tclk_d) runs <= runs + 1;
    if (!rst_n || rst_req) hr <= 0;
    else if (tgt_clk && !tclk_d && !tgt_rst_n) hr <= hr + 1;
  end

  always_comb begin
    if (tgt_rst_n)
      bad_now = (runs > lim_n) ||
                (blip_len > 0 && runs >= blip_at && runs < blip_at + blip_len);
    else
      bad_now = junk_rst;
    tgt_clk_ret = bad_now ? stuck_v : ~tgt_clk;
  end

  // ---------------- behavioural reference ----------------
  int  m_ph, m_hold, m_streak, m_good, m_hcnt;
  bit  m_tclk, m_run, m_badhi, m_halt;
  bit  sq[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_tclk = 1; m_run = 0; m_hold = 0;
      m_badhi = 0; m_streak = 0; m_good = 0; m_halt = 0; m_hcnt = 0;
      sq = {1'b0, 1'b0};
    end else begin
      bit e_hi, e_lo, rs, bad;
      e_hi = (m_ph == DIV - 1);
      e_lo = (m_ph == 2 * DIV - 1);
      rs = sq[0];
      void'(sq.pop_front());
      sq.push_back(tgt_clk_ret);
      if (rst_req) begin
        m_badhi = 0; m_streak = 0; m_good = 0; m_halt = 0; m_hcnt = 0;
      end else if (m_run && !m_halt) begin
        if (e_hi) m_badhi = rs;
        if (e_lo) begin
          bad = m_badhi || !rs;
          m_badhi = 0;
          if (bad) begin
            if (m_streak == HALT_RUN - 1) begin m_halt = 1; m_hcnt = m_good; end
            else m_streak++;
          end else begin
            m_streak = 0;
            if (m_good < CMAX) m_good++;
          end
        end
      end
      if (rst_req) begin m_run = 0; m_hold = 0; end
      else if (!m_run && e_lo) begin
        if (m_hold == HOLD_CYC) m_run = 1; else m_hold++;
      end
      m_ph   = e_lo ? 0 : m_ph + 1;
      m_tclk = (m_ph < DIV);
    end
  end

  task automatic chk(input string tag, input string what, input longint act,
                     input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1", "tgt_clk vs model", tgt_clk, m_tclk);
      chk("R3", "tgt_rst_n vs model", tgt_rst_n, m_run);
      chk("R6", "halt_flag vs model", halt_flag, m_halt);
      chk("R7", "halt_cycles vs model", halt_cycles, m_hcnt);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual expired expected finished");
    finish_run();
  end

  task automatic pulse_req();
    @(negedge clk) rst_req = 1'b1;
    @(negedge clk) rst_req = 1'b0;
  endtask

  task automatic wait_release();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (tgt_rst_n) begin
        chk("R3", "hold rises", hr, HOLD_CYC);
        chk("R4", "release on rising edge", tgt_clk && !tclk_d, 1);
        return;
      end
    end
    chk("R3", "release timeout", 0, 1);
  endtask

  task automatic wait_halt(input string tag, input int exp_cnt, input int exp_runs);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (halt_flag) begin
        chk(tag, "latched count", halt_cycles, exp_cnt);
        chk("R6", "target cycles at halt", runs, exp_runs);
        return;
      end
    end
    chk("R6", "halt timeout", 0, 1);
  endtask

  task automatic run_case(input string tag, input int n, input int b_at,
                          input int b_len, input bit sv, input bit junk,
                          input int exp_cnt, input int exp_runs);
    lim_n = n; blip_at = b_at; blip_len = b_len; stuck_v = sv; junk_rst = junk;
    pulse_req();
    chk("R8", "flag after request", halt_flag, 0);
    chk("R8", "count after request", halt_cycles, 0);
    chk("R8", "reset after request", tgt_rst_n, 0);
    wait_release();
    chk("R9", "no flag during hold", halt_flag, 0);
    wait_halt(tag, exp_cnt, exp_runs);
  endtask

  initial begin
    int t0;
    lim_n = 31; stuck_v = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2", "reset tgt_rst_n", tgt_rst_n, 0);
    chk("R2", "reset halt_flag", halt_flag, 0);
    chk("R2", "reset halt_cycles", halt_cycles, 0);
    // R3/R7: power-on hold, target halts stuck high after 31 good cycles
    wait_release();
    wait_halt("R7", 31, 31 + HALT_RUN);
    // R1: period of the target clock
    while (!(tgt_clk && !tclk_d)) @(negedge clk);
    t0 = 0;
    do begin @(negedge clk); t0++; end while (!(tgt_clk && !tclk_d));
    chk("R1", "target period", t0, 2 * DIV);
    // R8: result stays put
    repeat (50) @(negedge clk);
    chk("R8", "flag sticky", halt_flag, 1);
    chk("R8", "count sticky", halt_cycles, 31);
    // R5: stuck-low halt
    run_case("R5", 5, 0, 0, 1'b0, 1'b0, 5, 5 + HALT_RUN);
    // R6: short bad burst tolerated
    run_case("R6", 20, 8, HALT_RUN - 1, 1'b1, 1'b0, 20 - (HALT_RUN - 1), 20 + HALT_RUN);
    // R6: burst of exactly HALT_RUN halts
    run_case("R6", 50, 6, HALT_RUN, 1'b0, 1'b0, 5, 6 + HALT_RUN - 1);
    // R7: immediate halt, zero good cycles
    run_case("R7", 0, 0, 0, 1'b1, 1'b0, 0, HALT_RUN);
    // R7: saturation
    run_case("R7", 300, 0, 0, 1'b1, 1'b0, CMAX, 300 + HALT_RUN);
    // R9: junk on the return pin during hold
    run_case("R9", 12, 0, 0, 1'b1, 1'b1, 12, 12 + HALT_RUN);
    junk_rst = 1'b0;
    // R3/R8: request while running restarts the hold
    lim_n = 40; blip_len = 0;
    pulse_req();
    wait_release();
    repeat (10 * 2 * DIV) @(negedge clk);
    chk("R8", "no halt yet", halt_flag, 0);
    pulse_req();
    chk("R8", "reset after mid-run request", tgt_rst_n, 0);
    wait_release();
    wait_halt("R7", 40, 40 + HALT_RUN);
    repeat (20) @(negedge clk);
    finish_run();
  end

endmodule